// File: doc/BRIEF.md
# Priority-Sorting Interrupt Controller with Spurious Detection

The block gathers a vector of interrupt sources, by default 96 of them numbered 0 to 95. For each source it keeps a mask bit, a software-forced pending bit, a 6-bit priority and a route bit that sends the source to either the normal request output or the fast request output. Each of the two paths has its own sorter. When a path is idle and sees a pending, unmasked source routed to it, the sorter starts a fixed window of cycles, 10 by default. At the end of the window it picks the winner afresh from the sources that are still eligible. Priority 0 is the most urgent, and on equal priority the lower source number wins.

A path whose sort finds a winner stores the source number and priority and raises its output. The output stays high until software writes the release bit for that path. If nothing is eligible when the window closes, because the source dropped or a register write masked it, the result is spurious. Every flag bit above the number field of the status word then reads 1, so the word is negative. The number and priority fields keep their previous contents and the output stays low.

Software reaches the block over a plain word-addressed strobe bus. Reads are combinational and writes take effect on the clock edge where `bus_we` is high.

Top module: `intc_sort`

## Requirements
- R1: After reset both outputs are low, both path status words and both priority words read 0, every mask word reads 0xFFFFFFFF (all sources disabled), every software-pending bit is 0, and every level word reads 0.
- R2: Mask word w (address 8+w) holds the mask for sources 32w to 32w+31, with bit b belonging to source 32w+b. Writing address 11+w sets the mask bits that are written as 1, and writing address 14+w clears them. Both of these aliases read back the mask. A source whose mask bit is 1 never raises an output.
- R3: When an idle path first samples an eligible source on clock edge E0, its output rises on edge E10 and not before.
- R4: The winner is the eligible source with the smallest priority value. On equal priority the lower source number wins.
- R5: The level word of source n is at address 64+n. Bit 0 routes the source (0 to the normal output, 1 to the fast output) and bits [7:2] hold its priority. Each path sorts, reports and releases on its own.
- R6: The path status word (address 0 for the normal path, 2 for the fast path) holds the winning source number in bits [6:0]. The priority word (address 1 or 3) holds the winning priority in bits [5:0]. After a valid result, bits [31:7] of both words are 0.
- R7: If no source of a path is still eligible when its window ends, the result is spurious. Bits [31:7] of both words of that path become all 1, bits [6:0] keep their previous values, and the output is not raised. This applies whether the source drops or a mask write removes it.
- R8: A raised output holds its stored result while other sources arrive. Writing address 4 with bit 0 (normal path) or bit 1 (fast path) set lowers that output on the write edge and lets a new sort begin on the next edge.
- R9: Writing address 17+w sets software-pending bits and writing 20+w clears them. Either address reads back the bits. A software-pending source is eligible exactly like a hardware one.
- R10: Sources 64 to 95, held in the third mask word, are sorted and reported like the lower ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_i | input | NUM_SRC | Hardware interrupt request levels |
| bus_we | input | 1 | Write strobe |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| irq_o | output | 1 | Normal-path request |
| fiq_o | output | 1 | Fast-path request |

## Verification
The bench builds the block with its default parameters: 96 sources, 6-bit priorities and a 10-cycle window. With 96 sources the third mask word and the level words above address 127 are in use, so the highest-numbered sources are tested against lower ones. The full 10-cycle window lets a source drop or be masked in the middle of a sort. The output is sampled one cycle before and one cycle after the expected rise, which pins the window length exactly.

// File: rtl/intc_pkg.sv
package intc_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SORT = 2'd1,
    ST_HOLD = 2'd2
  } sort_st_e;

  localparam int PATH_NORM = 0;
  localparam int PATH_FAST = 1;

  // True when candidate a outranks candidate b: smaller priority wins,
  // equal priority falls to the smaller source number.
  function automatic logic outranks(input logic [7:0] pa, input int unsigned na,
                                    input logic [7:0] pb, input int unsigned nb);
    return (pa < pb) || ((pa == pb) && (na < nb));
  endfunction

  // Builds a status word: low field kept, all bits from fw upward set on spurious.
  function automatic logic [31:0] pack_status(input logic [31:0] field, input logic spur,
                                              input int unsigned fw);
    logic [31:0] hi;
    hi = ~32'd0 << fw;
    return spur ? (hi | (field & ~hi)) : (field & ~hi);
  endfunction

endpackage

// File: rtl/intc_pick.sv
module intc_pick #(
  parameter int NUM_SRC = 96,
  parameter int PRIO_W  = 6,
  parameter int NUM_W   = 7
) (
  input  logic [NUM_SRC-1:0]             elig,
  input  logic [NUM_SRC-1:0][PRIO_W-1:0] prio,
  output logic                           any,
  output logic [NUM_W-1:0]               win_num,
  output logic [PRIO_W-1:0]              win_prio
);
  import intc_pkg::*;

  always_comb begin
    any      = 1'b0;
    win_num  = '0;
    win_prio = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (elig[i]) begin
        if (!any || outranks(8'(prio[i]), i, 8'(win_prio), int'(win_num))) begin
          win_num  = NUM_W'(i);
          win_prio = prio[i];
        end
        any = 1'b1;
      end
    end
  end

endmodule

// File: rtl/intc_sorter.sv
module intc_sorter #(
  parameter int NUM_SRC     = 96,
  parameter int PRIO_W      = 6,
  parameter int NUM_W       = 7,
  parameter int SORT_CYCLES = 10
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [NUM_SRC-1:0]             elig,
  input  logic [NUM_SRC-1:0][PRIO_W-1:0] prio,
  input  logic                           ack,
  output logic                           out,
  output logic [31:0]                    act_w,
  output logic [31:0]                    pri_w,
  output logic                           ev_start,
  output logic                           ev_done,
  output logic                           ev_spur
);
  import intc_pkg::*;

  localparam int CNT_W = $clog2(SORT_CYCLES + 1);

  sort_st_e           st_q;
  logic [CNT_W-1:0]   cnt_q;
  logic               out_q;
  logic               spur_q;
  logic [NUM_W-1:0]   num_q;
  logic [PRIO_W-1:0]  prio_q;

  logic               pick_any;
  logic [NUM_W-1:0]   pick_num;
  logic [PRIO_W-1:0]  pick_prio;

  intc_pick #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .NUM_W(NUM_W)) u_pick (
    .elig     (elig),
    .prio     (prio),
    .any      (pick_any),
    .win_num  (pick_num),
    .win_prio (pick_prio)
  );

  assign ev_start = (st_q == ST_IDLE) && pick_any;
  assign ev_done  = (st_q == ST_SORT) && (cnt_q == CNT_W'(SORT_CYCLES - 1));
  assign ev_spur  = ev_done && !pick_any;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      out_q  <= 1'b0;
      spur_q <= 1'b0;
      num_q  <= '0;
      prio_q <= '0;
    end else begin
      case (st_q)
        ST_IDLE: begin
          if (ev_start) begin
            st_q  <= ST_SORT;
            cnt_q <= '0;
          end
        end
        ST_SORT: begin
          if (ev_done) begin
            if (pick_any) begin
              num_q  <= pick_num;
              prio_q <= pick_prio;
              spur_q <= 1'b0;
              out_q  <= 1'b1;
              st_q   <= ST_HOLD;
            end else begin
              spur_q <= 1'b1;
              st_q   <= ST_IDLE;
            end
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_HOLD: begin
          if (ack) begin
            out_q <= 1'b0;
            st_q  <= ST_IDLE;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign out   = out_q;
  assign act_w = pack_status(32'(num_q), spur_q, NUM_W);
  assign pri_w = pack_status(32'(prio_q), spur_q, NUM_W);

endmodule

// File: rtl/intc_regs.sv
module intc_regs #(
  parameter int NUM_SRC = 96,
  parameter int PRIO_W  = 6,
  parameter int ADDR_W  = 8
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           bus_we,
  input  logic [ADDR_W-1:0]              bus_addr,
  input  logic [31:0]                    bus_wdata,
  output logic [31:0]                    bus_rdata,
  input  logic [1:0][31:0]               act_w,
  input  logic [1:0][31:0]               pri_w,
  output logic [NUM_SRC-1:0]             mask,
  output logic [NUM_SRC-1:0]             sws,
  output logic [NUM_SRC-1:0]             lvl_fast,
  output logic [NUM_SRC-1:0][PRIO_W-1:0] lvl_prio,
  output logic [1:0]                     ack
);
  localparam int MW     = (NUM_SRC + 31) / 32;
  localparam int CTRL_A = 4;
  localparam int MASK_B = 8;
  localparam int SET_B  = MASK_B + MW;
  localparam int CLR_B  = SET_B + MW;
  localparam int SWS_B  = CLR_B + MW;
  localparam int SWC_B  = SWS_B + MW;
  localparam int LVL_B  = 64;
  localparam logic [MW*32-1:0] VALID = (MW*32)'({NUM_SRC{1'b1}});

  logic [MW*32-1:0]              mask_q, sws_q;
  logic [NUM_SRC-1:0]            fast_q;
  logic [NUM_SRC-1:0][PRIO_W-1:0] prio_q;

  function automatic logic hit(input logic [ADDR_W-1:0] a, input int unsigned target);
    return a == ADDR_W'(target);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q <= VALID;
      sws_q  <= '0;
      fast_q <= '0;
      prio_q <= '0;
    end else if (bus_we) begin
      for (int w = 0; w < MW; w++) begin
        if (hit(bus_addr, MASK_B + w)) mask_q[w*32 +: 32] <= bus_wdata & VALID[w*32 +: 32];
        if (hit(bus_addr, SET_B + w))
          mask_q[w*32 +: 32] <= mask_q[w*32 +: 32] | (bus_wdata & VALID[w*32 +: 32]);
        if (hit(bus_addr, CLR_B + w)) mask_q[w*32 +: 32] <= mask_q[w*32 +: 32] & ~bus_wdata;
        if (hit(bus_addr, SWS_B + w))
          sws_q[w*32 +: 32] <= sws_q[w*32 +: 32] | (bus_wdata & VALID[w*32 +: 32]);
        if (hit(bus_addr, SWC_B + w)) sws_q[w*32 +: 32] <= sws_q[w*32 +: 32] & ~bus_wdata;
      end
      for (int n = 0; n < NUM_SRC; n++) begin
        if (hit(bus_addr, LVL_B + n)) begin
          fast_q[n] <= bus_wdata[0];
          prio_q[n] <= bus_wdata[PRIO_W+1:2];
        end
      end
    end
  end

  assign ack = (bus_we && hit(bus_addr, CTRL_A)) ? bus_wdata[1:0] : 2'b00;

  always_comb begin
    bus_rdata = '0;
    if (hit(bus_addr, 0)) bus_rdata = act_w[0];
    if (hit(bus_addr, 1)) bus_rdata = pri_w[0];
    if (hit(bus_addr, 2)) bus_rdata = act_w[1];
    if (hit(bus_addr, 3)) bus_rdata = pri_w[1];
    for (int w = 0; w < MW; w++) begin
      if (hit(bus_addr, MASK_B + w) || hit(bus_addr, SET_B + w) || hit(bus_addr, CLR_B + w))
        bus_rdata = mask_q[w*32 +: 32];
      if (hit(bus_addr, SWS_B + w) || hit(bus_addr, SWC_B + w))
        bus_rdata = sws_q[w*32 +: 32];
    end
    for (int n = 0; n < NUM_SRC; n++) begin
      if (hit(bus_addr, LVL_B + n)) bus_rdata = 32'({prio_q[n], 1'b0, fast_q[n]});
    end
  end

  assign mask     = mask_q[NUM_SRC-1:0];
  assign sws      = sws_q[NUM_SRC-1:0];
  assign lvl_fast = fast_q;
  assign lvl_prio = prio_q;

endmodule

// File: rtl/intc_sort.sv
module intc_sort #(
  parameter int NUM_SRC     = 96,
  parameter int PRIO_W      = 6,
  parameter int SORT_CYCLES = 10,
  parameter int ADDR_W      = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic               bus_we,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  output logic               irq_o,
  output logic               fiq_o
);
  import intc_pkg::*;

  localparam int NUM_W = $clog2(NUM_SRC);
  localparam int FLG_W = 32 - NUM_W;

  logic [NUM_SRC-1:0]             mask, sws, lvl_fast, pend;
  logic [NUM_SRC-1:0][PRIO_W-1:0] lvl_prio;
  logic [1:0]                     ack, path_out, ev_start, ev_done, ev_spur;
  logic [1:0][31:0]               act_w, pri_w;
  logic [1:0][FLG_W-1:0]          act_flg, pri_flg;

  intc_regs #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .ADDR_W(ADDR_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .act_w     (act_w),
    .pri_w     (pri_w),
    .mask      (mask),
    .sws       (sws),
    .lvl_fast  (lvl_fast),
    .lvl_prio  (lvl_prio),
    .ack       (ack)
  );

  assign pend = src_i | sws;

  for (genvar p = 0; p < 2; p++) begin : g_path
    logic [NUM_SRC-1:0] elig;
    assign elig = pend & ~mask & ((p == PATH_FAST) ? lvl_fast : ~lvl_fast);

    intc_sorter #(
      .NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .NUM_W(NUM_W), .SORT_CYCLES(SORT_CYCLES)
    ) u_sort (
      .clk      (clk),
      .rst_n    (rst_n),
      .elig     (elig),
      .prio     (lvl_prio),
      .ack      (ack[p]),
      .out      (path_out[p]),
      .act_w    (act_w[p]),
      .pri_w    (pri_w[p]),
      .ev_start (ev_start[p]),
      .ev_done  (ev_done[p]),
      .ev_spur  (ev_spur[p])
    );

    assign act_flg[p] = act_w[p][31:NUM_W];
    assign pri_flg[p] = pri_w[p][31:NUM_W];
  end

  assign irq_o = path_out[PATH_NORM];
  assign fiq_o = path_out[PATH_FAST];

endmodule

// File: rtl/intc_sort_chk.sv
module intc_sort_chk #(
  parameter int SORT_CYCLES = 10,
  parameter int FLG_W       = 25
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [1:0]            ev_start,
  input logic [1:0]            ev_done,
  input logic [1:0]            ev_spur,
  input logic [1:0]            path_out,
  input logic [1:0]            ack,
  input logic [1:0][FLG_W-1:0] act_flg,
  input logic [1:0][FLG_W-1:0] pri_flg
);
  localparam int CW = $clog2(SORT_CYCLES + 1);

  for (genvar p = 0; p < 2; p++) begin : g_chk
    logic          busy_q;
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        busy_q <= 1'b0;
        cnt_q  <= '0;
      end else if (!busy_q && ev_start[p]) begin
        busy_q <= 1'b1;
        cnt_q  <= '0;
      end else if (busy_q) begin
        if (ev_done[p]) busy_q <= 1'b0;
        else            cnt_q  <= cnt_q + 1'b1;
      end
    end

    // R3: the sort closes exactly SORT_CYCLES cycles after it opened
    a_r3_window_len: assert property (@(posedge clk) disable iff (!rst_n)
      ev_done[p] |-> (busy_q && cnt_q == CW'(SORT_CYCLES - 1)));

    // R3: an output only rises on the edge that closes a sort
    a_r3_rise_after_sort: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(path_out[p]) |-> $past(ev_done[p]));

    // R6: a freshly raised output carries clear flag fields
    a_r6_valid_flags_clear: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(path_out[p]) |-> (act_flg[p] == '0 && pri_flg[p] == '0));

    // R7: a spurious end never raises the output
    a_r7_spur_no_out: assert property (@(posedge clk) disable iff (!rst_n)
      ev_spur[p] |=> !path_out[p]);

    // R7: a spurious end sets every flag bit in both words
    a_r7_spur_flags_set: assert property (@(posedge clk) disable iff (!rst_n)
      ev_spur[p] |=> (&act_flg[p] && &pri_flg[p]));

    // R8: output holds until released
    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (path_out[p] && !ack[p]) |=> path_out[p]);

    // R8: release drops the output on the write edge
    a_r8_release: assert property (@(posedge clk) disable iff (!rst_n)
      (path_out[p] && ack[p]) |=> !path_out[p]);
  end

endmodule

bind intc_sort intc_sort_chk #(.SORT_CYCLES(SORT_CYCLES), .FLG_W(FLG_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .ev_start (ev_start),
  .ev_done  (ev_done),
  .ev_spur  (ev_spur),
  .path_out (path_out),
  .ack      (ack),
  .act_flg  (act_flg),
  .pri_flg  (pri_flg)
);

// File: tb/intc_sort_tb.sv
`timescale 1ns/1ps
module intc_sort_tb_top;
  localparam int NUM_SRC = 96;
  localparam int ADDR_W  = 8;
  localparam int A_NACT = 0, A_NPRI = 1, A_FACT = 2, A_FPRI = 3, A_CTRL = 4;
  localparam int A_MASK = 8, A_SET = 11, A_CLR = 14, A_SWS = 17, A_SWC = 20, A_LVL = 64;

  typedef struct packed {
    logic [6:0] sa; logic [5:0] pa;
    logic [6:0] sb; logic [5:0] pb;
    logic       fast;
    logic [6:0] win; logic [5:0] wp;
  } vec_t;

  localparam vec_t VEC [6] = '{
    '{7'd3,  6'd5,  7'd7,  6'd2,  1'b0, 7'd7,  6'd2},
    '{7'd10, 6'd4,  7'd20, 6'd4,  1'b0, 7'd10, 6'd4},
    '{7'd90, 6'd1,  7'd2,  6'd9,  1'b1, 7'd90, 6'd1},
    '{7'd95, 6'd0,  7'd64, 6'd0,  1'b1, 7'd64, 6'd0},
    '{7'd40, 6'd63, 7'd41, 6'd62, 1'b0, 7'd41, 6'd62},
    '{7'd33, 6'd7,  7'd65, 6'd7,  1'b0, 7'd33, 6'd7}
  };

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic [NUM_SRC-1:0] src = '0;
  logic               bus_we = 1'b0;
  logic [ADDR_W-1:0]  bus_addr = '0;
  logic [31:0]        bus_wdata = '0;
  logic [31:0]        bus_rdata;
  logic               irq_o, fiq_o;
  int                 checks = 0;
  int                 failures = 0;
  bit                 done = 1'b0;

  always #5 clk = ~clk;

  intc_sort dut_i (
    .clk(clk), .rst_n(rst_n), .src_i(src), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o), .fiq_o(fiq_o)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=0x%08h exp=0x%08h", req, got, exp);
    end
  endtask

  task automatic waitn(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = ADDR_W'(a); bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = ADDR_W'(a);
    #1 d = bus_rdata;
  endtask

  function automatic logic [31:0] bitof(input int s);
    return 32'd1 << (s % 32);
  endfunction

  initial begin
    #2_000_000;
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    waitn(4);
    rst_n = 1'b1;
    waitn(1);

    // R1 reset state
    chk("R1 irq_o", 32'(irq_o), 0);
    chk("R1 fiq_o", 32'(fiq_o), 0);
    rd(A_NACT, d); chk("R1 norm act", d, 0);
    rd(A_FPRI, d); chk("R1 fast pri", d, 0);
    for (int w = 0; w < 3; w++) begin
      rd(A_MASK + w, d); chk("R1 mask word", d, 32'hFFFF_FFFF);
    end
    rd(A_SWS + 1, d); chk("R1 sw pending", d, 0);
    rd(A_LVL + 5, d); chk("R1 level", d, 0);

    // R2 mask write and aliases
    wr(A_MASK, 32'h0000_00F0);
    rd(A_MASK, d); chk("R2 mask write", d, 32'h0000_00F0);
    wr(A_SET, 32'h0000_0001);
    rd(A_SET, d); chk("R2 set alias", d, 32'h0000_00F1);
    wr(A_CLR, 32'h0000_0030);
    rd(A_CLR, d); chk("R2 clear alias", d, 32'h0000_00C1);
    wr(A_MASK, 32'hFFFF_FFFF);
    wr(A_LVL + 5, 32'h0000_0004);
    @(negedge clk) src[5] = 1'b1;
    waitn(14);
    chk("R2 masked source ignored", 32'(irq_o), 0);
    src[5] = 1'b0;

    // R3 window timing and R8 hold / release
    wr(A_LVL + 12, 32'(3 << 2));
    wr(A_LVL + 13, 32'(0));
    wr(A_CLR, bitof(12) | bitof(13));
    @(negedge clk) src[12] = 1'b1;
    waitn(10);
    chk("R3 low one cycle before window end", 32'(irq_o), 0);
    waitn(1);
    chk("R3 high at window end", 32'(irq_o), 1);
    rd(A_NACT, d); chk("R6 act number", d, 32'd12);
    rd(A_NPRI, d); chk("R6 act priority", d, 32'd3);
    src[13] = 1'b1;
    waitn(13);
    rd(A_NACT, d); chk("R8 result held", d, 32'd12);
    chk("R8 output held", 32'(irq_o), 1);
    src[12] = 1'b0;
    wr(A_CTRL, 32'h1);
    chk("R8 release drops output", 32'(irq_o), 0);
    waitn(12);
    chk("R8 next sort after release", 32'(irq_o), 1);
    rd(A_NACT, d); chk("R8 next winner", d, 32'd13);
    src[13] = 1'b0;
    wr(A_CTRL, 32'h1);

    // R7 spurious by deassert
    @(negedge clk) src[12] = 1'b1;
    waitn(4);
    src[12] = 1'b0;
    waitn(12);
    chk("R7 no output on spurious", 32'(irq_o), 0);
    rd(A_NACT, d); chk("R7 act negative, number kept", d, 32'hFFFF_FF8D);
    rd(A_NPRI, d); chk("R7 pri flags set", d, 32'hFFFF_FF80);
    rd(A_FACT, d); chk("R5 other path untouched", d, 0);

    // R6 valid sort clears flags again
    @(negedge clk) src[13] = 1'b1;
    waitn(12);
    rd(A_NACT, d); chk("R6 flags cleared", d, 32'd13);
    src[13] = 1'b0;
    wr(A_CTRL, 32'h1);

    // R7 spurious by mask write mid-sort
    @(negedge clk) src[12] = 1'b1;
    waitn(3);
    wr(A_SET, bitof(12));
    waitn(12);
    chk("R7 masked mid-sort no output", 32'(irq_o), 0);
    rd(A_NACT, d); chk("R7 masked mid-sort negative", d, 32'hFFFF_FF8D);
    src[12] = 1'b0;
    wr(A_SET, bitof(13));

    // R4 R5 R10 vector walk
    foreach (VEC[i]) begin
      vec_t v;
      v = VEC[i];
      wr(A_LVL + int'(v.sa), 32'({v.pa, 1'b0, v.fast}));
      wr(A_LVL + int'(v.sb), 32'({v.pb, 1'b0, v.fast}));
      wr(A_CLR + int'(v.sa) / 32, bitof(int'(v.sa)));
      wr(A_CLR + int'(v.sb) / 32, bitof(int'(v.sb)));
      @(negedge clk);
      src[v.sa] = 1'b1;
      src[v.sb] = 1'b1;
      waitn(12);
      chk("R5 routed output high", 32'(v.fast ? fiq_o : irq_o), 1);
      chk("R5 other output low", 32'(v.fast ? irq_o : fiq_o), 0);
      rd(v.fast ? A_FACT : A_NACT, d); chk("R4 R10 winner number", d, 32'(v.win));
      rd(v.fast ? A_FPRI : A_NPRI, d); chk("R4 winner priority", d, 32'(v.wp));
      src = '0;
      wr(A_SET + int'(v.sa) / 32, bitof(int'(v.sa)));
      wr(A_SET + int'(v.sb) / 32, bitof(int'(v.sb)));
      wr(A_CTRL, v.fast ? 32'h2 : 32'h1);
      waitn(2);
      chk("R8 released after vector", 32'(irq_o | fiq_o), 0);
    end

    // R9 software pending
    wr(A_LVL + 50, 32'((2 << 2) | 1));
    wr(A_CLR + 1, bitof(50));
    wr(A_SWS + 1, bitof(50));
    rd(A_SWS + 1, d); chk("R9 sw pending readback", d, bitof(50));
    waitn(12);
    chk("R9 sw pending raises fast output", 32'(fiq_o), 1);
    rd(A_FACT, d); chk("R9 sw winner", d, 32'd50);
    rd(A_FPRI, d); chk("R9 sw priority", d, 32'd2);
    wr(A_SWC + 1, bitof(50));
    wr(A_CTRL, 32'h2);
    rd(A_SWC + 1, d); chk("R9 sw pending cleared", d, 0);
    waitn(14);
    chk("R9 no new sort after clear", 32'(fiq_o), 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule